// File: doc/BRIEF.md
# Interrupt Status Hub

This block gathers interrupt events from a storage-bus controller and folds them into a two-level status structure. SCSI-type events are latched into two SCSI status registers. DMA-type events are latched into one DMA status register. A separate input sets an interrupt-on-the-fly flag. A top-level status word reports three things: whether any enabled SCSI bit is pending, whether any DMA bit is pending, and the state of the fly flag. An active-low request line is low whenever any of these three bits is set.

Software works through a simple register port. It reads the top-level word first and then reads whichever detailed register the summary points to. The detailed status registers clear when read. The fly flag clears only when software writes a one to its bit. While the script engine is busy, only the top-level word can be accessed. Any access to another address is flagged as unavailable and has no effect.

Top module: `irq_status_hub`

## Requirements
- R1: Synchronous active-low reset clears all status bits, both enable registers and the fly flag. After reset, `irq_n` is high and every register reads 0.
- R2: A one on any bit of `scsi_evt_a`, `scsi_evt_b` or `dma_evt` latches the matching status bit at the next clock edge, whether or not that bit is enabled. The latched bit is readable at address 1 (SCSI A), 2 (SCSI B) or 3 (DMA).
- R3: Bit 0 of the top word (address 0) is 1 exactly when any SCSI A status bit AND its enable bit (address 4) is set, or any SCSI B status bit AND its enable bit (address 5) is set.
- R4: Bit 1 of the top word is 1 exactly when any DMA status bit is set. DMA bits have no enable.
- R5: `irq_n` is low exactly when at least one of top-word bits 0, 1 or 2 is set.
- R6: Bit 2 of the top word is the fly flag. A `fly_evt` pulse sets it, even with bits 0 and 1 clear. Writing a 1 to bit 2 of address 0 clears it. Writing a 0 there leaves it unchanged.
- R7: A read of address 1, 2 or 3 returns the current value in the same cycle and clears that register at the clock edge that ends the read.
- R8: An event that arrives in the same cycle as a clear-on-read or a fly-flag clear wins: the bit is still set after that edge.
- R9: While `engine_busy` is high, address 0 stays readable and writable. Any access to another address returns 0 on `reg_rdata`, raises `reg_unavail` in that cycle, clears nothing and writes nothing.
- R10: Enable registers at addresses 4 and 5 are written whole and read back unchanged. They are not affected by reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| engine_busy | input | 1 | High while the script engine runs |
| reg_addr | input | 3 | Register address |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational during `reg_rd` |
| reg_unavail | output | 1 | Access refused because the engine is busy |
| scsi_evt_a | input | DATA_W | SCSI event pulses, first group |
| scsi_evt_b | input | DATA_W | SCSI event pulses, second group |
| dma_evt | input | DATA_W | DMA event pulses |
| fly_evt | input | 1 | Interrupt-on-the-fly event pulse |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Event pulses land in the status registers one clock edge after they are driven. `irq_n` and the top-word bits are decoded from registered state without further delay, so they change in that same cycle. Read data and `reg_unavail` are combinational and are valid in the cycle the read is driven. A clear-on-read or a fly-flag clear takes effect at the edge that ends the access. The bench drives each stimulus on a falling edge and samples combinational results 1 ns later. It samples registered results only after the following rising edge, so every check falls in the cycle in which its result is due.

// File: rtl/irq_hub_pkg.sv
// Package: shared address map and top-word bit positions for the
// interrupt status hub. Assumes a 3-bit register address space.
package irq_hub_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_TOP    = 3'd0,
        A_SCSI_A = 3'd1,
        A_SCSI_B = 3'd2,
        A_DMA    = 3'd3,
        A_EN_A   = 3'd4,
        A_EN_B   = 3'd5
    } reg_sel_e;

    localparam int TOP_SCSI_BIT = 0;
    localparam int TOP_DMA_BIT  = 1;
    localparam int TOP_FLY_BIT  = 2;
    localparam int TOP_BITS     = 3;
endpackage

// File: rtl/irq_evt_bank.sv
// Module: irq_evt_bank
// A bank of sticky event bits with a clear-on-read strobe.
// Assumes: events are single-cycle pulses in the clk domain. If an
// event and the clear strobe arrive in the same cycle, the event wins.
module irq_evt_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         clr,
    output logic [W-1:0] stat
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic bit_q;
        // Purpose: hold one sticky bit; a set in the same cycle beats the clear
        always_ff @(posedge clk) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= (bit_q & ~clr) | evt[i];
        end
        assign stat[i] = bit_q;
    end
endmodule

// File: rtl/irq_mask_reg.sv
// Module: irq_mask_reg
// A writable enable register, cleared by reset.
// Assumes: the write strobe is already qualified by the caller.
module irq_mask_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en
);
    // Purpose: load the whole enable word on a qualified write
    always_ff @(posedge clk) begin
        if (!rst_n)  en <= '0;
        else if (wr) en <= wdata;
    end
endmodule

// File: rtl/irq_fly_flag.sv
// Module: irq_fly_flag
// The interrupt-on-the-fly flag, cleared by writing a one.
// Assumes: clr_w1 is already decoded from a write with the flag bit at 1.
// A set in the same cycle beats the clear.
module irq_fly_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr_w1,
    output logic q
);
    // Purpose: keep the flag until it is cleared by a one written to it
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= (q & ~clr_w1) | set;
    end
endmodule

// File: rtl/irq_summary.sv
// Module: irq_summary
// Folds the detailed status into the pending bits and the request line.
// Assumes: all inputs are registered, so the outputs are glitch-free
// after each clock edge.
module irq_summary #(
    parameter int W = 8
) (
    input  logic [W-1:0] stat_a,
    input  logic [W-1:0] en_a,
    input  logic [W-1:0] stat_b,
    input  logic [W-1:0] en_b,
    input  logic [W-1:0] dma_stat,
    input  logic         fly,
    output logic         scsi_pend,
    output logic         dma_pend,
    output logic         irq_n
);
    // Purpose: OR-reduce the enabled SCSI bits and all DMA bits
    always_comb begin
        scsi_pend = |(stat_a & en_a) | |(stat_b & en_b);
        dma_pend  = |dma_stat;
        irq_n     = ~(scsi_pend | dma_pend | fly);
    end
endmodule

// File: rtl/irq_status_hub.sv
// Module: irq_status_hub (top)
// Two-level interrupt status: detailed SCSI and DMA registers that clear
// on read, a top-level summary word, the fly flag and an active-low
// request line.
// Assumes: DATA_W >= 3; at most one of reg_rd/reg_wr is high per cycle.
// While engine_busy is high, only address A_TOP may be accessed.
module irq_status_hub
    import irq_hub_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              engine_busy,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_unavail,
    input  logic [DATA_W-1:0] scsi_evt_a,
    input  logic [DATA_W-1:0] scsi_evt_b,
    input  logic [DATA_W-1:0] dma_evt,
    input  logic              fly_evt,
    output logic              irq_n
);
    localparam int PAD_W = DATA_W - TOP_BITS;

    logic              access_ok, rd_ok, wr_ok;
    logic              clr_a, clr_b, clr_dma, fly_clr;
    logic              wr_en_a, wr_en_b;
    logic [DATA_W-1:0] stat_a, stat_b, dma_stat, en_a, en_b;
    logic              fly_q, scsi_pend, dma_pend;
    logic [DATA_W-1:0] top_word;

    // Purpose: gate accesses by engine state and decode the strobes
    always_comb begin
        access_ok   = !engine_busy || (reg_addr == A_TOP);
        rd_ok       = reg_rd && access_ok;
        wr_ok       = reg_wr && access_ok;
        reg_unavail = (reg_rd || reg_wr) && !access_ok;
        clr_a       = rd_ok && (reg_addr == A_SCSI_A);
        clr_b       = rd_ok && (reg_addr == A_SCSI_B);
        clr_dma     = rd_ok && (reg_addr == A_DMA);
        wr_en_a     = wr_ok && (reg_addr == A_EN_A);
        wr_en_b     = wr_ok && (reg_addr == A_EN_B);
        fly_clr     = wr_ok && (reg_addr == A_TOP) && reg_wdata[TOP_FLY_BIT];
    end

    irq_evt_bank #(.W(DATA_W)) u_bank_a (
        .clk(clk), .rst_n(rst_n), .evt(scsi_evt_a), .clr(clr_a), .stat(stat_a));
    irq_evt_bank #(.W(DATA_W)) u_bank_b (
        .clk(clk), .rst_n(rst_n), .evt(scsi_evt_b), .clr(clr_b), .stat(stat_b));
    irq_evt_bank #(.W(DATA_W)) u_bank_dma (
        .clk(clk), .rst_n(rst_n), .evt(dma_evt), .clr(clr_dma), .stat(dma_stat));

    irq_mask_reg #(.W(DATA_W)) u_en_a (
        .clk(clk), .rst_n(rst_n), .wr(wr_en_a), .wdata(reg_wdata), .en(en_a));
    irq_mask_reg #(.W(DATA_W)) u_en_b (
        .clk(clk), .rst_n(rst_n), .wr(wr_en_b), .wdata(reg_wdata), .en(en_b));

    irq_fly_flag u_fly (
        .clk(clk), .rst_n(rst_n), .set(fly_evt), .clr_w1(fly_clr), .q(fly_q));

    irq_summary #(.W(DATA_W)) u_sum (
        .stat_a(stat_a), .en_a(en_a), .stat_b(stat_b), .en_b(en_b),
        .dma_stat(dma_stat), .fly(fly_q),
        .scsi_pend(scsi_pend), .dma_pend(dma_pend), .irq_n(irq_n));

    // Purpose: assemble the top-level summary word
    always_comb begin
        top_word                = '0;
        top_word[TOP_SCSI_BIT]  = scsi_pend;
        top_word[TOP_DMA_BIT]   = dma_pend;
        top_word[TOP_FLY_BIT]   = fly_q;
    end

    // Purpose: read-data multiplexer; refused or idle reads return zero
    always_comb begin
        reg_rdata = '0;
        if (rd_ok) begin
            case (reg_addr)
                A_TOP:    reg_rdata = top_word;
                A_SCSI_A: reg_rdata = stat_a;
                A_SCSI_B: reg_rdata = stat_b;
                A_DMA:    reg_rdata = dma_stat;
                A_EN_A:   reg_rdata = en_a;
                A_EN_B:   reg_rdata = en_b;
                default:  reg_rdata = '0;
            endcase
        end
    end

    if (PAD_W < 0) begin : g_bad_width
        initial $error("DATA_W must be at least %0d", TOP_BITS);
    end
endmodule

// File: rtl/irq_status_hub_chk.sv
// Module: irq_status_hub_chk
// Assertion checker bound to irq_status_hub. It observes the ports and
// the registered status state.
module irq_status_hub_chk
    import irq_hub_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              engine_busy,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              reg_unavail,
    input logic [DATA_W-1:0] scsi_evt_a,
    input logic [DATA_W-1:0] dma_evt,
    input logic              fly_evt,
    input logic              irq_n,
    input logic [DATA_W-1:0] stat_a,
    input logic [DATA_W-1:0] dma_stat,
    input logic              fly_q
);
    // R1: the first cycle after reset shows no request
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> irq_n);

    // R2 and R8: a SCSI event is latched even when a clear arrives with it
    assert_evt_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (scsi_evt_a != '0) |=> ((stat_a & $past(scsi_evt_a)) == $past(scsi_evt_a)));

    // R4 and R5: a DMA event always leads to a request
    assert_dma_requests_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_evt != '0) |=> !irq_n);

    // R5: a fly event always leads to a request
    assert_fly_requests_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fly_evt |=> !irq_n);

    // R6: writing a zero to the fly bit leaves the flag set
    assert_fly_w0_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_TOP && !reg_wdata[TOP_FLY_BIT] && fly_q) |=> fly_q);

    // R8: a fly event wins over a clear in the same cycle
    assert_fly_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fly_evt |=> fly_q);

    // R9: a refused access is only possible while the engine is busy
    assert_unavail_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_unavail |-> engine_busy);

    // R9: a refused DMA read clears no bit
    assert_busy_no_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (engine_busy && reg_rd && reg_addr == A_DMA)
        |=> ((dma_stat & $past(dma_stat)) == $past(dma_stat)));
endmodule

bind irq_status_hub irq_status_hub_chk #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .engine_busy(engine_busy), .reg_addr(reg_addr),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_unavail(reg_unavail), .scsi_evt_a(scsi_evt_a), .dma_evt(dma_evt),
    .fly_evt(fly_evt), .irq_n(irq_n), .stat_a(stat_a), .dma_stat(dma_stat),
    .fly_q(fly_q));

// File: tb/irq_status_hub_tb_top.sv
// Directed bench for irq_status_hub: one task per scenario.
// Inputs are driven on falling edges. Combinational results are sampled
// 1 ns later; registered results are sampled one edge after the stimulus.
module irq_status_hub_tb_top;
    localparam int DW = 8;
    localparam logic [2:0] AT = 3'd0, AA = 3'd1, AB = 3'd2, AD = 3'd3,
                           EA = 3'd4, EB = 3'd5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          engine_busy = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic          reg_rd = 1'b0, reg_wr = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          reg_unavail;
    logic [DW-1:0] scsi_evt_a = '0, scsi_evt_b = '0, dma_evt = '0;
    logic          fly_evt = 1'b0;
    logic          irq_n;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    irq_status_hub #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .engine_busy(engine_busy),
        .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_unavail(reg_unavail), .scsi_evt_a(scsi_evt_a),
        .scsi_evt_b(scsi_evt_b), .dma_evt(dma_evt), .fly_evt(fly_evt),
        .irq_n(irq_n));

    task automatic chk(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one read access; data and unavail sampled inside the cycle
    task automatic rd(input logic [2:0] a, output logic [DW-1:0] d,
                      output logic u);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1; d = reg_rdata; u = reg_unavail;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] v);
        @(negedge clk);
        reg_addr = a; reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input logic [DW-1:0] ea, input logic [DW-1:0] eb,
                         input logic [DW-1:0] ed, input logic f);
        @(negedge clk);
        scsi_evt_a = ea; scsi_evt_b = eb; dma_evt = ed; fly_evt = f;
        @(negedge clk);
        scsi_evt_a = '0; scsi_evt_b = '0; dma_evt = '0; fly_evt = 1'b0;
    endtask

    task automatic t_reset();
        logic [DW-1:0] d; logic u;
        chk("R1 irq_n", {7'd0, irq_n}, 8'd1);
        rd(AT, d, u); chk("R1 top", d, 8'h00);
        rd(EA, d, u); chk("R1 en_a", d, 8'h00);
        rd(AD, d, u); chk("R1 dma", d, 8'h00);
    endtask

    task automatic t_masked();
        logic [DW-1:0] d; logic u;
        pulse(8'h05, 8'h00, 8'h00, 1'b0);
        rd(AT, d, u); chk("R3 masked top", d, 8'h00);
        chk("R5 masked irq_n", {7'd0, irq_n}, 8'd1);
        rd(AA, d, u); chk("R2 latch A", d, 8'h05);
        rd(AA, d, u); chk("R7 cleared A", d, 8'h00);
    endtask

    task automatic t_enabled();
        logic [DW-1:0] d; logic u;
        wr(EA, 8'h04); rd(EA, d, u); chk("R10 en_a readback", d, 8'h04);
        rd(EA, d, u); chk("R10 en_a kept after read", d, 8'h04);
        wr(EB, 8'h80); rd(EB, d, u); chk("R10 en_b readback", d, 8'h80);
        pulse(8'h04, 8'h00, 8'h00, 1'b0);
        chk("R5 irq_n low scsi", {7'd0, irq_n}, 8'd0);
        rd(AT, d, u); chk("R3 top scsi", d, 8'h01);
        rd(AA, d, u); chk("R7 read A", d, 8'h04);
        rd(AT, d, u); chk("R3 top after read", d, 8'h00);
        chk("R5 irq_n back high", {7'd0, irq_n}, 8'd1);
        pulse(8'h00, 8'h81, 8'h00, 1'b0);
        rd(AT, d, u); chk("R3 top via B", d, 8'h01);
        rd(AB, d, u); chk("R2 latch B", d, 8'h81);
        chk("R3 irq_n after B read", {7'd0, irq_n}, 8'd1);
    endtask

    task automatic t_dma();
        logic [DW-1:0] d; logic u;
        pulse(8'h00, 8'h00, 8'h80, 1'b0);
        rd(AT, d, u); chk("R4 top dma", d, 8'h02);
        chk("R5 irq_n dma", {7'd0, irq_n}, 8'd0);
        rd(AD, d, u); chk("R7 read dma", d, 8'h80);
        rd(AT, d, u); chk("R4 top cleared", d, 8'h00);
    endtask

    task automatic t_fly();
        logic [DW-1:0] d; logic u;
        pulse(8'h00, 8'h00, 8'h00, 1'b1);
        rd(AT, d, u); chk("R6 fly alone", d, 8'h04);
        chk("R5 irq_n fly", {7'd0, irq_n}, 8'd0);
        wr(AT, 8'hFB);
        rd(AT, d, u); chk("R6 write zero kept", d, 8'h04);
        wr(AT, 8'h04);
        rd(AT, d, u); chk("R6 write one clears", d, 8'h00);
        chk("R5 irq_n after fly clear", {7'd0, irq_n}, 8'd1);
    endtask

    task automatic t_collide();
        logic [DW-1:0] d; logic u;
        pulse(8'h00, 8'h00, 8'h02, 1'b0);
        @(negedge clk);
        reg_addr = AD; reg_rd = 1'b1; dma_evt = 8'h01;
        #1; d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0; dma_evt = '0;
        chk("R7 read during event", d, 8'h02);
        rd(AD, d, u); chk("R8 event beats clear", d, 8'h01);
        @(negedge clk);
        reg_addr = AT; reg_wr = 1'b1; reg_wdata = 8'h04; fly_evt = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; fly_evt = 1'b0;
        rd(AT, d, u); chk("R8 fly set beats clear", d, 8'h04);
        wr(AT, 8'h04);
    endtask

    task automatic t_busy();
        logic [DW-1:0] d; logic u;
        pulse(8'h00, 8'h00, 8'h10, 1'b1);
        engine_busy = 1'b1;
        rd(AD, d, u);
        chk("R9 busy dma data", d, 8'h00);
        chk("R9 busy unavail", {7'd0, u}, 8'd1);
        rd(AT, d, u);
        chk("R9 busy top data", d, 8'h06);
        chk("R9 busy top avail", {7'd0, u}, 8'd0);
        wr(EA, 8'hFF);
        wr(AT, 8'h04);
        rd(AT, d, u); chk("R9 busy fly clear", d, 8'h02);
        engine_busy = 1'b0;
        rd(EA, d, u); chk("R9 busy write ignored", d, 8'h04);
        rd(AD, d, u); chk("R9 dma kept", d, 8'h10);
        chk("R9 avail again", {7'd0, u}, 8'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_masked();
        t_enabled();
        t_dma();
        t_fly();
        t_collide();
        t_busy();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule